// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block times the strobe of one task-file access on an ATA channel that serves two drives. Each drive has its own timing byte: the upper nibble gives the active strobe length in clocks and the lower nibble gives an encoded recovery length. The channel also holds a 2-bit address-setup code for each drive. When a request arrives with a drive select and a direction, the block first holds the address for the setup time. It then drives the read or write strobe for the active time and keeps the channel busy through recovery. Only after recovery does it pulse done.

The block can be built in two ways. With `SHARED_SETUP = 0`, each drive has its own setup register, and the block uses the slower of the two settings no matter which drive is addressed. With `SHARED_SETUP = 1`, one common setup register serves both drives. In that case software must program the slower value itself, and the second setup register is ignored. In both builds the byte at address 2 also holds a sticky channel interrupt flag in bit 4. A write that updates the setup field with bit 4 low leaves the flag as it was.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset the outputs `busy`, `rd_strobe`, `wr_strobe`, `done` and `irq_flag` are low, and every drive is timed as 5 setup, 16 active and 16 recovery clocks.
- R2: Timing bytes sit at address 0 (drive 0) and address 1 (drive 1). Bits 7:4 give the active clocks, and a value of 0 means 16 clocks.
- R3: Bits 3:0 of a timing byte are the recovery code. Codes 1 to 14 give code+1 clocks, and codes 0 and 15 both give 16 clocks.
- R4: The setup code sits in bits 7:6 of address 2 (drive 0 or common) and address 3 (drive 1). The code 01 gives 2 clocks, 10 gives 3, 00 gives 4 and 11 gives 5.
- R5: With `SHARED_SETUP = 0`, every access uses the larger of the two decoded setup times, for either drive.
- R6: With `SHARED_SETUP = 1`, every access uses the setup code at address 2, and writes to address 3 have no effect on timing.
- R7: A high `irq_set` sets `irq_flag`. A write to address 2 with bit 4 high clears it, unless `irq_set` is high in the same cycle. A write to address 2 with bit 4 low leaves it unchanged.
- R8: An accepted request keeps `busy` high for setup+active+recovery clocks. The selected strobe is high for exactly the active clocks, starting after the setup clocks. `req_write` high selects `wr_strobe`, otherwise `rd_strobe` is used, and the other strobe stays low. `done` pulses for one clock right after `busy` falls.
- R9: A request is accepted only while `busy` is low. A request raised during a busy cycle is dropped, not queued.
- R10: Timing and setup values are sampled at acceptance, so register writes made during a cycle affect only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address (0,1 timing; 2,3 setup) |
| cfg_wdata | input | 8 | Register write data |
| irq_set | input | 1 | Sets the channel interrupt flag |
| req_valid | input | 1 | Access request, taken when idle |
| req_drive | input | 1 | Drive select of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| busy | output | 1 | Access in progress (setup, active, recovery) |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| done | output | 1 | One-clock pulse after recovery ends |
| irq_flag | output | 1 | Channel interrupt flag (bit 4 of address 2) |

## Verification
On every cycle the assertions check the following: the two strobes never overlap, and a strobe appears only inside a busy period. A strobe never rises straight out of idle, recovery always follows its fall, and done is a single pulse outside busy. They also check that a setup write with bit 4 low keeps the interrupt flag steady. Only the bench scenarios show the exact clock counts. These include the decoding of every setup code and of the boundary recovery codes, and the choice of the slower setup in the split build against the common register in the shared build. The scenarios also cover dropped requests while busy and the sampling of register values at acceptance.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;
  localparam int CNT_W = 5;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOV} phase_e;

  // Active nibble: zero wraps to 16 clocks.
  function automatic logic [CNT_W-1:0] act_clks(input logic [3:0] n);
    return (n == 4'd0) ? CNT_W'(16) : {1'b0, n};
  endfunction

  // Recovery code: 0 and 15 mean 16, others mean code+1.
  function automatic logic [CNT_W-1:0] rec_clks(input logic [3:0] c);
    if (c == 4'd0 || c == 4'd15) return CNT_W'(16);
    return {1'b0, c} + CNT_W'(1);
  endfunction

  // Address setup code to clocks.
  function automatic logic [CNT_W-1:0] setup_clks(input logic [1:0] s);
    case (s)
      2'b01:   return CNT_W'(2);
      2'b10:   return CNT_W'(3);
      2'b00:   return CNT_W'(4);
      default: return CNT_W'(5);
    endcase
  endfunction
endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int NDRV   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              irq_set,
  output logic [DATA_W-1:0] tim0,
  output logic [DATA_W-1:0] tim1,
  output logic [1:0]        su0,
  output logic [1:0]        su1,
  output logic              irq_flag
);
  localparam int SU_HI   = DATA_W - 1;
  localparam int FLAG_B  = 4;

  logic [DATA_W-1:0] tim_mem [NDRV];
  logic [1:0]        su_mem  [NDRV];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NDRV; i++) begin
        tim_mem[i] <= '0;
        su_mem[i]  <= 2'b11;
      end
    end else if (we) begin
      if (!addr[1]) tim_mem[addr[0]] <= wdata;
      else          su_mem[addr[0]]  <= wdata[SU_HI -: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                       irq_flag <= 1'b0;
    else if (irq_set)                              irq_flag <= 1'b1;
    else if (we && addr == 2 && wdata[FLAG_B])     irq_flag <= 1'b0;
  end

  assign tim0 = tim_mem[0];
  assign tim1 = tim_mem[1];
  assign su0  = su_mem[0];
  assign su1  = su_mem[1];

  // R7
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 2 && !wdata[FLAG_B] && !irq_set) |=> $stable(irq_flag));
endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
  import pio_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             wr_in,
  input  logic [CNT_W-1:0] setup_n,
  input  logic [CNT_W-1:0] act_n,
  input  logic [CNT_W-1:0] rec_n,
  output logic             busy,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             done
);
  phase_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, act_q, act_d, rec_q, rec_d;
  logic             wr_q, wr_d, done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    rec_d  = rec_q;
    wr_d   = wr_q;
    done_d = 1'b0;
    case (st_q)
      PH_IDLE: if (start) begin
        st_d  = PH_SETUP;
        cnt_d = setup_n - CNT_W'(1);
        act_d = act_n;
        rec_d = rec_n;
        wr_d  = wr_in;
      end
      PH_SETUP: if (cnt_q == '0) begin
        st_d  = PH_ACTIVE;
        cnt_d = act_q - CNT_W'(1);
      end else cnt_d = cnt_q - CNT_W'(1);
      PH_ACTIVE: if (cnt_q == '0) begin
        st_d  = PH_RECOV;
        cnt_d = rec_q - CNT_W'(1);
      end else cnt_d = cnt_q - CNT_W'(1);
      default: if (cnt_q == '0) begin
        st_d   = PH_IDLE;
        done_d = 1'b1;
      end else cnt_d = cnt_q - CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      act_q  <= '0;
      rec_q  <= '0;
      wr_q   <= 1'b0;
      busy   <= 1'b0;
      rd_stb <= 1'b0;
      wr_stb <= 1'b0;
      done   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      rec_q  <= rec_d;
      wr_q   <= wr_d;
      busy   <= (st_d != PH_IDLE);
      rd_stb <= (st_d == PH_ACTIVE) && !wr_d;
      wr_stb <= (st_d == PH_ACTIVE) && wr_d;
      done   <= done_d;
    end
  end

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && wr_stb));
  // R8
  stb_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb || wr_stb) |-> busy);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R4
  setup_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_stb || wr_stb) |-> $past(busy));
  // R3
  recov_after_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_stb || wr_stb) |-> busy);
endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
  import pio_timing_pkg::*;
#(
  parameter int SHARED_SETUP = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       irq_set,
  input  logic       req_valid,
  input  logic       req_drive,
  input  logic       req_write,
  output logic       busy,
  output logic       rd_strobe,
  output logic       wr_strobe,
  output logic       done,
  output logic       irq_flag
);
  logic [7:0]       tim0, tim1, tim_sel;
  logic [1:0]       su0, su1;
  logic [CNT_W-1:0] setup_n, act_n, rec_n;
  logic             start;

  pio_cfg_regs #(.ADDR_W(2), .DATA_W(8), .NDRV(2)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .irq_set(irq_set), .tim0(tim0), .tim1(tim1), .su0(su0), .su1(su1),
    .irq_flag(irq_flag)
  );

  assign tim_sel = req_drive ? tim1 : tim0;
  assign act_n   = act_clks(tim_sel[7:4]);
  assign rec_n   = rec_clks(tim_sel[3:0]);

  generate
    if (SHARED_SETUP != 0) begin : g_common
      logic unused_su1;
      assign unused_su1 = ^su1;
      assign setup_n    = setup_clks(su0);
    end else begin : g_split
      logic [CNT_W-1:0] s0, s1;
      assign s0      = setup_clks(su0);
      assign s1      = setup_clks(su1);
      assign setup_n = (s0 > s1) ? s0 : s1;
    end
  endgenerate

  assign start = req_valid && !busy;

  pio_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .wr_in(req_write),
    .setup_n(setup_n), .act_n(act_n), .rec_n(rec_n),
    .busy(busy), .rd_stb(rd_strobe), .wr_stb(wr_strobe), .done(done)
  );
endmodule

// File: tb/tb_pio_cycle_timer.sv
module tb_pio_cycle_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic irq_set = 1'b0;
  logic req_valid = 1'b0;
  logic req_drive = 1'b0;
  logic req_write = 1'b0;
  logic bsy [2];
  logic rds [2];
  logic wrs [2];
  logic dn  [2];
  logic flg [2];

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_cycle_timer #(.SHARED_SETUP(0)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .irq_set(irq_set), .req_valid(req_valid), .req_drive(req_drive), .req_write(req_write),
    .busy(bsy[0]), .rd_strobe(rds[0]), .wr_strobe(wrs[0]), .done(dn[0]), .irq_flag(flg[0])
  );

  pio_cycle_timer #(.SHARED_SETUP(1)) dut_sh (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .irq_set(irq_set), .req_valid(req_valid), .req_drive(req_drive), .req_write(req_write),
    .busy(bsy[1]), .rd_strobe(rds[1]), .wr_strobe(wrs[1]), .done(dn[1]), .irq_flag(flg[1])
  );

  typedef struct {
    int su;
    int ac;
    int rc;
    bit wr;
    logic [31:0] tag;
  } exp_t;

  exp_t q0[$];
  exp_t q1[$];

  logic [7:0] sh_tim [2];
  logic [1:0] sh_su  [2];

  function automatic int m_act(input logic [3:0] n);
    return (n == 0) ? 16 : int'(n);
  endfunction
  function automatic int m_rec(input logic [3:0] c);
    return (c == 0 || c == 15) ? 16 : int'(c) + 1;
  endfunction
  function automatic int m_su(input logic [1:0] s);
    case (s)
      2'b01: return 2;
      2'b10: return 3;
      2'b00: return 4;
      default: return 5;
    endcase
  endfunction

  task automatic chk(input bit ok, input logic [31:0] tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  int m_s [2];
  int m_a [2];
  int m_r [2];
  bit m_sw [2];
  bit m_sr [2];

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_s[i] = 0; m_a[i] = 0; m_r[i] = 0; m_sw[i] = 0; m_sr[i] = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < 2; i++) begin
        if (bsy[i]) begin
          if (rds[i] || wrs[i]) begin
            m_a[i]++;
            if (wrs[i]) m_sw[i] = 1;
            if (rds[i]) m_sr[i] = 1;
          end else if (m_a[i] == 0) m_s[i]++;
          else m_r[i]++;
        end
        if (dn[i]) begin
          exp_t e;
          bit have;
          have = (i == 0) ? (q0.size() > 0) : (q1.size() > 0);
          chk(have, "R9", 1, 0);
          if (have) begin
            e = (i == 0) ? q0.pop_front() : q1.pop_front();
            chk(m_s[i] == e.su, e.tag, m_s[i], e.su);
            chk(m_a[i] == e.ac, e.tag, m_a[i], e.ac);
            chk(m_r[i] == e.rc, e.tag, m_r[i], e.rc);
            chk((m_sw[i] == e.wr) && (m_sr[i] == !e.wr), "R8", {m_sw[i], m_sr[i]}, {e.wr, !e.wr});
          end
          m_s[i] = 0; m_a[i] = 0; m_r[i] = 0; m_sw[i] = 0; m_sr[i] = 0;
        end
      end
    end
  end

  // Driver tasks: called just after a falling edge
  task automatic wr_cfg(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    if (!a[1]) sh_tim[a[0]] = d;
    else       sh_su[a[0]]  = d[7:6];
  endtask

  task automatic issue_req(input bit drv, input bit wr, input logic [31:0] tag);
    exp_t e;
    int s0, s1;
    s0 = m_su(sh_su[0]);
    s1 = m_su(sh_su[1]);
    e.ac = m_act(sh_tim[drv][7:4]);
    e.rc = m_rec(sh_tim[drv][3:0]);
    e.wr = wr;
    e.tag = tag;
    e.su = (s0 > s1) ? s0 : s1;   // R5 split build
    q0.push_back(e);
    e.su = s0;                    // R6 common register build
    q1.push_back(e);
    req_valid = 1'b1; req_drive = drv; req_write = wr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (bsy[0] || bsy[1]) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input bit drv, input bit wr, input logic [31:0] tag);
    issue_req(drv, wr, tag);
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    sh_tim[0] = 8'h00; sh_tim[1] = 8'h00;
    sh_su[0] = 2'b11;  sh_su[1] = 2'b11;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state at the ports
    for (int i = 0; i < 2; i++)
      chk(!bsy[i] && !rds[i] && !wrs[i] && !dn[i] && !flg[i], "R1",
          {bsy[i], rds[i], wrs[i], dn[i], flg[i]}, 0);
    run(1'b1, 1'b0, "R1");
    run(1'b0, 1'b1, "R1");

    // R2 / R3 active and recovery decode
    wr_cfg(2'd0, 8'h35);
    run(1'b0, 1'b1, "R2");
    wr_cfg(2'd1, 8'h1E);
    run(1'b1, 1'b0, "R3");
    wr_cfg(2'd1, 8'h2F);
    run(1'b1, 1'b0, "R3");
    wr_cfg(2'd0, 8'h40);
    run(1'b0, 1'b0, "R3");
    wr_cfg(2'd0, 8'h31);
    run(1'b0, 1'b1, "R2");

    // R4 each setup code, drive 1 register at the fastest code
    wr_cfg(2'd3, 8'h40);
    for (int c = 0; c < 4; c++) begin
      wr_cfg(2'd2, 8'(c << 6));
      run(1'b0, 1'b0, "R4");
    end

    // R5 / R6 slower drive setup vs common register
    wr_cfg(2'd2, 8'h40);
    wr_cfg(2'd3, 8'hC0);
    run(1'b0, 1'b0, "R5");
    run(1'b1, 1'b1, "R6");
    wr_cfg(2'd3, 8'h80);
    run(1'b1, 1'b0, "R5");

    // R10 write during a cycle only affects later cycles
    issue_req(1'b0, 1'b0, "R10");
    wr_cfg(2'd0, 8'h23);
    wr_cfg(2'd2, 8'h00);
    wait_idle();
    run(1'b0, 1'b0, "R10");

    // R9 request while busy is dropped
    issue_req(1'b1, 1'b1, "R9");
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (bsy[0] || bsy[1]) seen++;
      end
      chk(seen == 0, "R9", seen, 0);
    end

    // R7 interrupt flag in the setup byte
    irq_set = 1'b1;
    @(posedge clk);
    @(negedge clk);
    irq_set = 1'b0;
    chk(flg[0] && flg[1], "R7", {flg[0], flg[1]}, 3);
    wr_cfg(2'd2, 8'h80);
    chk(flg[0] && flg[1], "R7", {flg[0], flg[1]}, 3);
    wr_cfg(2'd3, 8'h50);
    chk(flg[0] && flg[1], "R7", {flg[0], flg[1]}, 3);
    wr_cfg(2'd2, 8'h50);
    chk(!flg[0] && !flg[1], "R7", {flg[0], flg[1]}, 0);
    run(1'b1, 1'b0, "R4");

    chk(q0.size() == 0 && q1.size() == 0, "R8", q0.size() + q1.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule